// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a parallel NOR-style flash bus. It decides when a program or erase operation inside the flash has finished. It does not generate bus-cycle timing. Instead it asks a separate bus engine for reads through a ready/valid request channel, then looks at three status bits in each word that comes back:

- bit 7, the completion bit;
- bit 6, the toggle bit;
- bit 5, the time-limit bit.

A run starts with a one-cycle `start` pulse. With it the host supplies the word address to watch, the data that was written, a limit on polling rounds and a mode. The mode is `0` for completion-bit polling and `1` for toggle checking.

The block keeps reading until it reaches a verdict. When the time-limit bit is seen set, it always takes one further look, because the primary status bit can settle in the same instant as the time-limit bit. If the verdict is a failure, the block issues a single write request of the reset command word `0xF0` to the watched address, which returns the flash to array reads. It then raises `done` with `pass` low. After a success it raises `done` with `pass` high and issues no write. `done` and `pass` stay where they are until the next accepted `start`.

Top module: `flash_done_poller`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done`, `pass`, `rd_req_valid` and `wr_req_valid` are all 0.
- R2: In mode 0, a returned word whose bit 7 equals bit 7 of `exp_data` ends the run with pass, after exactly that read and with no write request.
- R3: In mode 0, a returned word whose bit 7 differs from bit 7 of `exp_data` and whose bit 5 is 0 causes another read of the same address, and the comparison repeats.
- R4: In mode 0, a mismatching word with bit 5 equal to 1 causes exactly one further read. If bit 7 of that read matches, the run passes; otherwise it fails.
- R5: In mode 1, the block reads twice. If bit 6 is the same in both words, the run passes after those two reads.
- R6: In mode 1, if bit 6 differs between the two words and bit 5 of the second word is 0, the block reads another pair and checks again.
- R7: In mode 1, if bit 6 differs and bit 5 of the second word is 1, the block reads exactly two more words. Equal bit 6 in that pair gives pass; different bit 6 gives fail.
- R8: On a fail verdict the block makes exactly one write request, with data `0xF0` at the watched address. The request is held until `wr_req_ready` accepts it. `done` rises with `pass` 0 in the cycle after acceptance, and no read request is ever active at the same time as the write request.
- R9: A round is one read in mode 0, or one pair of reads in mode 1. A round that resolves neither to pass nor to the bit-5 recheck counts as unresolved. The run fails after `max(max_polls,1)` unresolved rounds.
- R10: `rd_req_valid` is held with a stable `rd_req_addr` until `rd_req_ready`. After an accepted request no new request is made until a response arrives, and `rd_rsp_valid` has no effect while no read is outstanding.
- R11: `done` and `pass` hold their values until the next `start`. A `start` in a done state clears `done` one cycle later. A `start` while a run is in progress is ignored.
- R12: A pass verdict raises `done` in the cycle directly after the clock edge that takes the deciding response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a run |
| mode | input | 1 | 0: completion-bit polling, 1: toggle checking |
| poll_addr | input | AW | Word address to watch, sampled at start |
| exp_data | input | DW | Data that was programmed, sampled at start |
| max_polls | input | CW | Limit on unresolved rounds, sampled at start (0 acts as 1) |
| rd_req_valid | output | 1 | Read request to the bus engine |
| rd_req_ready | input | 1 | Bus engine accepts the read request |
| rd_req_addr | output | AW | Read address |
| rd_rsp_valid | input | 1 | Read data is present |
| rd_rsp_data | input | DW | Read data word |
| wr_req_valid | output | 1 | Reset-command write request |
| wr_req_ready | input | 1 | Bus engine accepts the write |
| wr_req_addr | output | AW | Write address |
| wr_req_data | output | DW | Write data (reset command) |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | Verdict of the last run; valid with done |

## Verification
The hardest situation to reach is a word whose time-limit bit is set on the very read that first shows the mismatch or toggle. The recheck read that follows then decides the verdict in either direction. The bench drives this from a per-run response script, handing back a fixed sequence of status words one per accepted read. Each script both ends on a late match and ends on a persistent mismatch. The same scripts run the round limit down to its boundary values of 0, 1 and 2. A slow-ready bus engine and a stray response sent while a request is still pending exercise the handshake rules.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

    // Status bit positions inside a returned flash word
    localparam int unsigned BIT_DONE = 7;
    localparam int unsigned BIT_TOG  = 6;
    localparam int unsigned BIT_TMO  = 5;

    // Command word that returns the flash to array reads
    localparam logic [7:0] RESET_CMD = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } state_t;

    // Which read of the sequence is outstanding
    typedef enum logic [2:0] {
        PH_DPOLL,
        PH_DRECHK,
        PH_TFIRST,
        PH_TSECOND,
        PH_TRC_FIRST,
        PH_TRC_SECOND
    } phase_t;

    typedef enum logic [1:0] {
        VD_CONT,
        VD_RETRY,
        VD_PASS,
        VD_FAIL
    } verdict_t;

    typedef struct packed {
        logic done_match;
        logic toggled;
        logic timeout;
    } status_t;

    function automatic phase_t first_phase(input logic toggle_mode);
        return toggle_mode ? PH_TFIRST : PH_DPOLL;
    endfunction

    function automatic logic captures_toggle(input phase_t ph);
        return (ph == PH_TFIRST) || (ph == PH_TRC_FIRST);
    endfunction

endpackage

// File: rtl/fdp_status_eval.sv
module fdp_status_eval
    import fdp_pkg::*;
#(
    parameter int DW = 16
) (
    input  phase_t         phase,
    input  logic [DW-1:0]  rsp_data,
    input  logic [DW-1:0]  exp_data,
    input  logic           prev_tog,
    input  logic           limit_hit,
    output verdict_t       verdict,
    output phase_t         next_phase
);

    status_t st;

    always_comb begin
        st.done_match = (rsp_data[BIT_DONE] == exp_data[BIT_DONE]);
        st.toggled    = (rsp_data[BIT_TOG] != prev_tog);
        st.timeout    = rsp_data[BIT_TMO];
    end

    always_comb begin
        verdict    = VD_FAIL;
        next_phase = phase;
        unique case (phase)
            PH_DPOLL: begin
                if (st.done_match) begin
                    verdict = VD_PASS;
                end else if (st.timeout) begin
                    verdict    = VD_CONT;
                    next_phase = PH_DRECHK;
                end else if (limit_hit) begin
                    verdict = VD_FAIL;
                end else begin
                    verdict    = VD_RETRY;
                    next_phase = PH_DPOLL;
                end
            end
            PH_DRECHK: begin
                verdict = st.done_match ? VD_PASS : VD_FAIL;
            end
            PH_TFIRST: begin
                verdict    = VD_CONT;
                next_phase = PH_TSECOND;
            end
            PH_TSECOND: begin
                if (!st.toggled) begin
                    verdict = VD_PASS;
                end else if (st.timeout) begin
                    verdict    = VD_CONT;
                    next_phase = PH_TRC_FIRST;
                end else if (limit_hit) begin
                    verdict = VD_FAIL;
                end else begin
                    verdict    = VD_RETRY;
                    next_phase = PH_TFIRST;
                end
            end
            PH_TRC_FIRST: begin
                verdict    = VD_CONT;
                next_phase = PH_TRC_SECOND;
            end
            PH_TRC_SECOND: begin
                verdict = st.toggled ? VD_FAIL : VD_PASS;
            end
            default: begin
                verdict = VD_FAIL;
            end
        endcase
    end

endmodule

// File: rtl/fdp_poll_limit.sv
module fdp_poll_limit #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          bump,
    input  logic [CW-1:0] max_polls,
    output logic          limit_hit
);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   cnt_next;
    logic [CW:0]   eff_max;

    always_comb begin
        cnt_next  = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
        eff_max   = (max_polls == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, max_polls};
        limit_hit = (cnt_next >= eff_max);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (bump && !cnt_next[CW]) begin
            cnt_q <= cnt_next[CW-1:0];
        end
    end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fdp_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode,
    input  logic [AW-1:0] poll_addr,
    input  logic [DW-1:0] exp_data,
    input  logic [CW-1:0] max_polls,
    output logic          rd_req_valid,
    input  logic          rd_req_ready,
    output logic [AW-1:0] rd_req_addr,
    input  logic          rd_rsp_valid,
    input  logic [DW-1:0] rd_rsp_data,
    output logic          wr_req_valid,
    input  logic          wr_req_ready,
    output logic [AW-1:0] wr_req_addr,
    output logic [DW-1:0] wr_req_data,
    output logic          done,
    output logic          pass
);

    state_t        st_q, st_d;
    phase_t        ph_q, ph_d;
    phase_t        eval_next;
    verdict_t      vd;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] exp_q;
    logic [CW-1:0] max_q;
    logic          tog_q;
    logic          done_q, pass_q;
    logic          start_acc, rsp_take, lim_hit, bump;

    assign start_acc = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
    assign rsp_take  = (st_q == ST_WAIT) && rd_rsp_valid;
    assign bump      = rsp_take && (vd == VD_RETRY);

    fdp_status_eval #(.DW(DW)) u_eval (
        .phase      (ph_q),
        .rsp_data   (rd_rsp_data),
        .exp_data   (exp_q),
        .prev_tog   (tog_q),
        .limit_hit  (lim_hit),
        .verdict    (vd),
        .next_phase (eval_next)
    );

    fdp_poll_limit #(.CW(CW)) u_limit (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_acc),
        .bump      (bump),
        .max_polls (max_q),
        .limit_hit (lim_hit)
    );

    always_comb begin
        st_d = st_q;
        ph_d = ph_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start_acc) begin
                    st_d = ST_REQ;
                    ph_d = first_phase(mode);
                end
            end
            ST_REQ: begin
                if (rd_req_ready) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_rsp_valid) begin
                    unique case (vd)
                        VD_CONT, VD_RETRY: begin
                            st_d = ST_REQ;
                            ph_d = eval_next;
                        end
                        VD_PASS: st_d = ST_DONE;
                        default: st_d = ST_WRITE;
                    endcase
                end
            end
            ST_WRITE: begin
                if (wr_req_ready) st_d = ST_DONE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ph_q   <= PH_DPOLL;
            addr_q <= '0;
            exp_q  <= '0;
            max_q  <= '0;
            tog_q  <= 1'b0;
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
            if (start_acc) begin
                addr_q <= poll_addr;
                exp_q  <= exp_data;
                max_q  <= max_polls;
                done_q <= 1'b0;
                pass_q <= 1'b0;
            end
            if (rsp_take && captures_toggle(ph_q)) begin
                tog_q <= rd_rsp_data[BIT_TOG];
            end
            if (rsp_take && vd == VD_PASS) begin
                done_q <= 1'b1;
                pass_q <= 1'b1;
            end
            if (st_q == ST_WRITE && wr_req_ready) begin
                done_q <= 1'b1;
                pass_q <= 1'b0;
            end
        end
    end

    assign rd_req_valid = (st_q == ST_REQ);
    assign rd_req_addr  = addr_q;
    assign wr_req_valid = (st_q == ST_WRITE);
    assign wr_req_addr  = addr_q;
    assign wr_req_data  = DW'(RESET_CMD);
    assign done         = done_q;
    assign pass         = pass_q;

endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          rd_req_valid,
    input logic          rd_req_ready,
    input logic [AW-1:0] rd_req_addr,
    input logic          wr_req_valid,
    input logic          wr_req_ready,
    input logic [AW-1:0] wr_req_addr,
    input logic          done,
    input logic          pass
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R10

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && rd_req_ready |=> !rd_req_valid); // R10

    AST_NO_BUS_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(rd_req_valid && wr_req_valid)); // R8

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_req_valid && !wr_req_ready |=> wr_req_valid && $stable(wr_req_addr)); // R8

    AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_req_valid && wr_req_ready |=> done && !pass && !wr_req_valid); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(pass)); // R11

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        done && start |=> !done); // R11

    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req_valid && !wr_req_valid); // R11

endmodule

bind flash_done_poller fdp_checker #(.AW(AW), .DW(DW)) u_fdp_checker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .wr_req_valid (wr_req_valid),
    .wr_req_ready (wr_req_ready),
    .wr_req_addr  (wr_req_addr),
    .done         (done),
    .pass         (pass)
);

// File: tb/test_flash_done_poller.sv
module test_flash_done_poller;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int CW = 16;

    typedef struct packed {
        logic        mode;
        logic [7:0]  exp;
        logic [7:0]  maxp;
        logic [47:0] resp;      // first response in the top byte
        logic        exp_pass;
        logic [3:0]  exp_reads;
        logic        exp_wr;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h80, 8'd8, 48'h80_80_80_80_80_80, 1'b1, 4'd1, 1'b0}, // R2
        '{1'b0, 8'h00, 8'd8, 48'h80_00_00_00_00_00, 1'b1, 4'd2, 1'b0}, // R3
        '{1'b0, 8'h80, 8'd8, 48'h20_80_80_80_80_80, 1'b1, 4'd2, 1'b0}, // R4 late match
        '{1'b0, 8'h80, 8'd8, 48'h20_20_20_20_20_20, 1'b0, 4'd2, 1'b1}, // R4 fail
        '{1'b1, 8'h00, 8'd8, 48'h40_40_40_40_40_40, 1'b1, 4'd2, 1'b0}, // R5
        '{1'b1, 8'h00, 8'd8, 48'h40_00_00_00_00_00, 1'b1, 4'd4, 1'b0}, // R6
        '{1'b1, 8'h00, 8'd8, 48'h00_60_40_40_40_40, 1'b1, 4'd4, 1'b0}, // R7 pass
        '{1'b1, 8'h00, 8'd8, 48'h00_60_00_40_40_40, 1'b0, 4'd4, 1'b1}, // R7 fail
        '{1'b0, 8'h80, 8'd2, 48'h00_00_00_00_00_00, 1'b0, 4'd2, 1'b1}, // R9 limit 2
        '{1'b1, 8'h00, 8'd1, 48'h00_40_00_40_00_40, 1'b0, 4'd2, 1'b1}, // R9 limit 1
        '{1'b0, 8'h80, 8'd0, 48'h00_00_00_00_00_00, 1'b0, 4'd1, 1'b1}, // R9 limit 0
        '{1'b0, 8'h80, 8'd8, 48'h00_00_00_80_80_80, 1'b1, 4'd4, 1'b0}  // R3 several
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic [DW-1:0] exp_data = '0;
    logic [CW-1:0] max_polls = '0;
    logic          rd_req_valid;
    logic          rd_req_ready = 1'b0;
    logic [AW-1:0] rd_req_addr;
    logic          rd_rsp_valid = 1'b0;
    logic [DW-1:0] rd_rsp_data = '0;
    logic          wr_req_valid;
    logic          wr_req_ready = 1'b0;
    logic [AW-1:0] wr_req_addr;
    logic [DW-1:0] wr_req_data;
    logic          done;
    logic          pass;

    flash_done_poller #(.AW(AW), .DW(DW), .CW(CW)) i_flash_done_poller (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .poll_addr(poll_addr), .exp_data(exp_data), .max_polls(max_polls),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .wr_req_valid(wr_req_valid),
        .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
        .wr_req_data(wr_req_data), .done(done), .pass(pass)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // responder state
    bit            auto_en = 1'b0;
    bit            rdy_phase = 1'b0;
    int            lat = 0;
    int            ridx = 0;
    logic [47:0]   cur_resp = '0;
    int            nreads = 0;
    int            nwrites = 0;
    int            bad_raddr = 0;
    logic [AW-1:0] last_waddr = '0;
    logic [DW-1:0] last_wdata = '0;

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Bus engine model: ready every other cycle, response two cycles after acceptance
    initial forever begin
        @(negedge clk);
        if (auto_en) begin
            rd_rsp_valid = 1'b0;
            if (lat != 0) begin
                lat--;
                if (lat == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = {8'h00, cur_resp[47-8*ridx -: 8]};
                    if (ridx < 5) ridx++;
                end
            end
            rdy_phase    = ~rdy_phase;
            rd_req_ready = rdy_phase;
            wr_req_ready = rdy_phase;
            if (rd_req_valid && rd_req_ready) begin
                nreads++;
                if (rd_req_addr != poll_addr) bad_raddr++;
                lat = 2;
            end
            if (wr_req_valid && wr_req_ready) begin
                nwrites++;
                last_waddr = wr_req_addr;
                last_wdata = wr_req_data;
            end
        end
    end

    // Called at a negedge; issues a start pulse and resets the responder script
    task automatic launch(input vec_t v, input logic [AW-1:0] a);
        mode      = v.mode;
        exp_data  = {8'h00, v.exp};
        max_polls = CW'(v.maxp);
        poll_addr = a;
        cur_resp  = v.resp;
        ridx = 0; lat = 0; nreads = 0; nwrites = 0; bad_raddr = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 400 && !done; k++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=0 expected=1");
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!done && !pass && !rd_req_valid && !wr_req_valid, "R1 in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !pass && !rd_req_valid && !wr_req_valid, "R1 after reset", int'(done), 0);

        // R10/R12: manual bus, stray response while request pending
        launch('{1'b0, 8'h80, 8'd8, 48'h0, 1'b1, 4'd1, 1'b0}, 24'h000123);
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = 16'h0080;
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        chk(!done && rd_req_valid, "R10 stray response ignored", int'(done), 0);
        chk(rd_req_addr == 24'h000123, "R10 request address", int'(rd_req_addr), 'h123);
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        chk(!rd_req_valid, "R10 single outstanding", int'(rd_req_valid), 0);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = 16'h0080;
        chk(!done, "R12 done not early", int'(done), 0);
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        chk(done && pass, "R12 done one cycle after response", int'(done), 1);

        // Table walk
        auto_en = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            launch(VECS[i], AW'(24'h010000 + i));
            chk(!done, $sformatf("R11 start clears done v%0d", i), int'(done), 0);
            wait_done();
            @(negedge clk);
            chk(done == 1'b1, $sformatf("R11 done v%0d", i), int'(done), 1);
            chk(pass == VECS[i].exp_pass, $sformatf("R2-R9 verdict v%0d", i),
                int'(pass), int'(VECS[i].exp_pass));
            chk(nreads == int'(VECS[i].exp_reads), $sformatf("R3-R9 read count v%0d", i),
                nreads, int'(VECS[i].exp_reads));
            chk(nwrites == int'(VECS[i].exp_wr), $sformatf("R8 write count v%0d", i),
                nwrites, int'(VECS[i].exp_wr));
            chk(bad_raddr == 0, $sformatf("R3 read address v%0d", i), bad_raddr, 0);
            if (VECS[i].exp_wr) begin
                chk(last_wdata == 16'h00F0, $sformatf("R8 reset command data v%0d", i),
                    int'(last_wdata), 'hF0);
                chk(last_waddr == AW'(24'h010000 + i), $sformatf("R8 write address v%0d", i),
                    int'(last_waddr), 'h10000 + i);
            end
        end

        // R11: hold after done
        begin
            logic p0;
            p0 = pass;
            repeat (6) @(negedge clk);
            chk(done && pass == p0, "R11 done and pass held", int'(pass), int'(p0));
        end

        // R11: start during a run is ignored
        launch(VECS[1], 24'h000777);
        repeat (2) @(negedge clk);
        mode = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        chk(done && pass, "R11 busy start ignored verdict", int'(pass), 1);
        chk(nreads == 2, "R11 busy start ignored reads", nreads, 2);

        // R1: reset in the middle of a run
        launch(VECS[8], 24'h000555);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!done && !rd_req_valid && !wr_req_valid, "R1 mid-run reset", int'(rd_req_valid), 0);

        report();
    end

endmodule